// File: doc/BRIEF.md
# Per-Client Hot Reset and DMA Blocker

This unit sits between a set of memory clients and the memory arbiter so that software can isolate any one client before resetting it. A shared gate register decides, one bit per client, whether new requests from that client may be accepted. A shared hold register drives an active-low hot reset line to each client. For every client a counter tracks transactions that were accepted but have not yet completed. Software reads this counter to learn when a client's traffic has drained.

The usual sequence is as follows. Software clears the client's gate bit. It then polls that client's outstanding counter until it reads zero, clears the client's hold bit to put the client in reset, and later sets both bits again. Completions keep arriving from a blocked client and keep draining its counter. Requests are accepted in the same cycle they are presented, through a combinational gate on the request strobe.

Top module: `client_isolator`

## Requirements
- R1: After reset, the gate register (word address 0) and the hold register (word address 1) read all ones in bits 0 to NUM_CLIENTS-1. Every outstanding counter reads zero and every `cli_rst_n` line is high.
- R2: A zero in bit i of the gate register stops client i's requests from being accepted, starting with the cycle after the write. A one in that bit lets them through again.
- R3: `cli_rst_n[i]` follows bit i of the hold register from the cycle after a write to that register. A zero asserts hot reset to the client and a one releases it.
- R4: Bit i of the hold register reads zero exactly while client i is held in reset.
- R5: Client i's outstanding counter is at word address 16+i. It increases by one in each cycle that a request from client i is accepted and no completion arrives.
- R6: A completion that arrives while the counter is zero leaves it at zero. The counter never underflows.
- R7: A counter at its maximum value (2^CNT_W-1) blocks further accepts from that client until a completion arrives.
- R8: Completions from a blocked client still decrement its counter.
- R9: An accept and a completion for the same client in the same cycle leave the counter unchanged.
- R10: A client held in reset has no requests accepted, even if its gate bit is one.
- R11: Register bits above NUM_CLIENTS read zero. Any address that maps to no register reads zero.
- R12: `cli_accept[i]` is high in the cycle in which `cli_req[i]` is high and the client is neither blocked, held in reset nor full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for writes and reads |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| cli_req | input | NUM_CLIENTS | Per-client request strobe |
| cli_done | input | NUM_CLIENTS | Per-client completion strobe |
| cli_accept | output | NUM_CLIENTS | Per-client request accept |
| cli_rst_n | output | NUM_CLIENTS | Per-client active-low hot reset |

## Verification
The counter assertions assume that a client raises `cli_done` only for a transaction it has in flight, or raises it by mistake at zero, which R6 covers. They also assume that strobes are sampled once per cycle. The bench keeps to these assumptions. It raises completions only for clients whose expected count it knows, and it issues one stray completion on purpose at count zero. Every input changes just after a rising edge and stays steady through the next edge, so the combinational accept path is always observed on settled values.

// File: rtl/client_isolator.sv
module client_isolator #(
  parameter int NUM_CLIENTS = 15,
  parameter int CNT_W       = 6,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int STAT_BASE   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  output logic [DATA_W-1:0]      reg_rdata,
  input  logic [NUM_CLIENTS-1:0] cli_req,
  input  logic [NUM_CLIENTS-1:0] cli_done,
  output logic [NUM_CLIENTS-1:0] cli_accept,
  output logic [NUM_CLIENTS-1:0] cli_rst_n
);

  localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] HOLD_ADDR = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam int                PAD_W     = DATA_W - NUM_CLIENTS;

  initial begin
    if (STAT_BASE + NUM_CLIENTS > (1 << ADDR_W) || STAT_BASE < 2)
      $error("client_isolator: status window does not fit the address space");
    if (NUM_CLIENTS > DATA_W || CNT_W > DATA_W)
      $error("client_isolator: register width too small");
  end

  logic [NUM_CLIENTS-1:0] gate_q, hold_q, full;
  logic [CNT_W-1:0]       cnt_q [NUM_CLIENTS];
  logic                   unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CLIENTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '1;
      hold_q <= '1;
    end else if (reg_we) begin
      if (reg_addr == GATE_ADDR) gate_q <= reg_wdata[NUM_CLIENTS-1:0];
      if (reg_addr == HOLD_ADDR) hold_q <= reg_wdata[NUM_CLIENTS-1:0];
    end
  end

  assign cli_accept = cli_req & gate_q & hold_q & ~full;
  assign cli_rst_n  = hold_q;

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_cli
    assign full[i] = (cnt_q[i] == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt_q[i] <= '0;
      else if (cli_accept[i] && !cli_done[i])
        cnt_q[i] <= cnt_q[i] + CNT_W'(1);
      else if (!cli_accept[i] && cli_done[i] && cnt_q[i] != '0)
        cnt_q[i] <= cnt_q[i] - CNT_W'(1);
    end

    p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cli_accept[i] && !cli_done[i]) |=> (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)));
    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cli_accept[i] && cli_done[i] && cnt_q[i] != '0) |=> (cnt_q[i] == $past(cnt_q[i]) - CNT_W'(1)));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cli_accept[i] && cli_done[i] && cnt_q[i] == '0) |=> (cnt_q[i] == '0));
    p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cli_accept[i] && cli_done[i]) |=> $stable(cnt_q[i]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == GATE_ADDR) reg_rdata = {{PAD_W{1'b0}}, gate_q};
    if (reg_addr == HOLD_ADDR) reg_rdata = {{PAD_W{1'b0}}, hold_q};
    for (int i = 0; i < NUM_CLIENTS; i++)
      if (reg_addr == ADDR_W'(STAT_BASE + i))
        reg_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_q[i]};
  end

  p_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == GATE_ADDR) |=>
      ((cli_accept & ~$past(reg_wdata[NUM_CLIENTS-1:0])) == '0));
  p_hot_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == HOLD_ADDR) |=>
      (cli_rst_n == $past(reg_wdata[NUM_CLIENTS-1:0])));
  p_reset_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == HOLD_ADDR) |=>
      ((cli_accept & ~$past(reg_wdata[NUM_CLIENTS-1:0])) == '0));

endmodule

// File: tb/sim_client_isolator.sv
module sim_client_isolator;
  localparam int N  = 15;
  localparam int CW = 3;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [N-1:0] cli_req = 0, cli_done = 0, cli_accept, cli_rst_n;

  int checks = 0, errors = 0, cycles = 0;
  int          sel_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  client_isolator #(.NUM_CLIENTS(N), .CNT_W(CW)) u0 (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .cli_req, .cli_done, .cli_accept, .cli_rst_n);

  task automatic step(input logic we, input logic [5:0] a, input logic [31:0] d,
                      input logic [N-1:0] rq, input logic [N-1:0] dn);
    @(posedge clk); #1;
    reg_we = we; reg_addr = a; reg_wdata = d; cli_req = rq; cli_done = dn;
  endtask

  task automatic expect_val(input int sel, input logic [31:0] e, input string t);
    sel_q.push_back(sel); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    step(0, a, 0, 0, 0);
    expect_val(0, e, t);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0);
  endtask

  always begin
    @(negedge clk);
    while (sel_q.size() > 0) begin
      int s; logic [31:0] e, g; string t;
      s = sel_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      g = (s == 0) ? reg_rdata : (s == 1) ? 32'(cli_accept) : 32'(cli_rst_n);
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL %s sel=%0d got=%h exp=%h", t, s, g, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(0, 32'h7fff, "R1 gate"); expect_val(2, 32'h7fff, "R1 rst_n");
    rd(1, 32'h7fff, "R1 hold");
    rd(16, 0, "R1 count");
    // R12 same-cycle accept, R5 increment at address 16+i
    step(0, 0, 0, 15'h0005, 0); expect_val(1, 32'h0005, "R12 accept");
    rd(16, 1, "R5 client0"); rd(18, 1, "R5 client2");
    // R2 block client 0
    wr(0, 32'h7ffe);
    step(0, 0, 0, 15'h0003, 0); expect_val(1, 32'h0002, "R2 blocked");
    rd(16, 1, "R2 count unchanged"); rd(17, 1, "R5 client1");
    // R8 blocked completion drains
    step(0, 0, 0, 0, 15'h0001);
    rd(16, 0, "R8 drained");
    // R6 stray completion at zero
    step(0, 0, 0, 0, 15'h0001);
    rd(16, 0, "R6 no underflow");
    // R9 accept and completion together
    step(0, 0, 0, 15'h0004, 15'h0004); expect_val(1, 32'h0004, "R9 accept");
    rd(18, 1, "R9 held");
    // R7 saturation on client 3
    for (int k = 0; k < 7; k++) step(0, 0, 0, 15'h0008, 0);
    rd(19, 7, "R7 at max");
    step(0, 0, 0, 15'h0008, 0); expect_val(1, 32'h0000, "R7 full blocks");
    rd(19, 7, "R7 still max");
    // R3/R4/R10 hot reset of client 4
    wr(1, 32'h7fef);
    rd(1, 32'h7fef, "R4 bit4 zero"); expect_val(2, 32'h7fef, "R3 rst_n low");
    step(0, 0, 0, 15'h0010, 0); expect_val(1, 32'h0000, "R10 reset gates");
    rd(20, 0, "R10 count zero");
    // R11 upper bits, R3 release
    wr(1, 32'hffffffff);
    rd(1, 32'h7fff, "R11 hold upper zero"); expect_val(2, 32'h7fff, "R3 release");
    // R2 unblock
    wr(0, 32'hffffffff);
    step(0, 0, 0, 15'h0001, 0); expect_val(1, 32'h0001, "R2 unblocked");
    rd(0, 32'h7fff, "R11 gate upper zero");
    // R11 unmapped
    rd(5, 0, "R11 unmapped 5"); rd(31, 0, "R11 unmapped 31");
    step(0, 0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule